// File: doc/BRIEF.md
# Per-Pin Edge Wakeup and Interrupt Controller

This block watches an eight-pin general-purpose port and records, per pin, when a transition of the chosen direction arrives. Each pin has an enable bit, a direction bit and a pending bit. A qualifying transition on an enabled pin latches that pin's pending bit, which stays set until software clears it through a small register port.

The enabled pending bits are OR-ed together to form two requests. The halt-exit request is raised for any such bit, with no further gating, so a core in its halt power state can always be released. The interrupt request carries the same condition, gated by a global interrupt enable held in the top bit of a control register. Pin inputs are asynchronous and pass through a synchronizer before edge detection.

Top module: `edge_wake_ctrl`

## Requirements
- R1: After reset, all four registers read 0 and both `irq_o` and `halt_exit_o` are low.
- R2: With direction bit 0 (rising), a 0-to-1 change on an enabled pin sets its pending bit, visible on the third rising clock edge after the pin change and not earlier.
- R3: With direction bit 1 (falling), a 1-to-0 change on an enabled pin sets its pending bit with the same three-edge latency.
- R4: A transition in the direction opposite to the pin's direction bit leaves its pending bit unchanged.
- R5: A transition on a pin whose enable bit is 0 does not set its pending bit.
- R6: A write to the pending register (address 2) clears each bit written as 0 and leaves each bit written as 1 unchanged; pending bits never clear without such a write.
- R7: When a qualifying edge and a clearing write to the same pending bit meet at the same clock edge, the bit ends up set.
- R8: Changing a pin's direction bit, with the pin level held steady, does not set its pending bit.
- R9: `irq_o` is high exactly when the global interrupt enable is 1 and some pin has both its pending and enable bits set.
- R10: `halt_exit_o` is high exactly when some pin has both its pending and enable bits set, whatever the global interrupt enable.
- R11: Register map: address 0 enable, address 1 direction, address 2 pending, address 3 control; bit i of registers 0 to 2 belongs to pin i; the global interrupt enable is bit 7 of address 3, and the other control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 8 | Asynchronous port pin levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data, combinational |
| irq_o | output | 1 | Interrupt request |
| halt_exit_o | output | 1 | Halt-exit request |

## Verification
The two functions that can collide are the setting of a pending bit by a detected edge and its clearing by a software write. The bench moves a pin, counts the clock edges through the synchronizer and the edge register, and places the clearing write so that it is sampled on the very edge where the detector fires. It judges the outcome by reading the pending register back afterwards: the colliding bit must still be set while another pending bit cleared by the same write must be gone.

// File: rtl/wk_pkg.sv
package wk_pkg;
    localparam int unsigned WK_ADDR_W = 2;

    typedef enum logic [WK_ADDR_W-1:0] {
        WK_ADDR_EN   = 2'd0,
        WK_ADDR_SEL  = 2'd1,
        WK_ADDR_PEND = 2'd2,
        WK_ADDR_CTRL = 2'd3
    } wk_addr_e;
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < int'(STAGES); g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/wk_edge.sv
module wk_edge #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] dir_i,
    output logic [W-1:0] hit_o
);
    logic [W-1:0] prev_d;
    logic [W-1:0] prev_q;

    always_comb begin
        prev_d = lvl_i;
        // a change whose new level differs from the direction bit:
        // dir 0 -> new level 1 (rising), dir 1 -> new level 0 (falling)
        hit_o  = (lvl_i ^ prev_q) & (lvl_i ^ dir_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/wk_regs.sv
module wk_regs
    import wk_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [WK_ADDR_W-1:0] wr_addr_i,
    input  logic [W-1:0]         wr_data_i,
    input  logic [W-1:0]         hit_i,
    output logic [W-1:0]         en_o,
    output logic [W-1:0]         dir_o,
    output logic [W-1:0]         pend_o,
    output logic                 gie_o
);
    typedef struct packed {
        logic [W-1:0] en;
        logic [W-1:0] dir;
        logic [W-1:0] pend;
        logic         gie;
    } wk_state_t;

    wk_state_t st_d;
    wk_state_t st_q;
    logic [W-1:0] clr_mask;

    always_comb begin
        st_d     = st_q;
        clr_mask = '0;
        if (wr_en_i) begin
            case (wk_addr_e'(wr_addr_i))
                WK_ADDR_EN:   st_d.en  = wr_data_i;
                WK_ADDR_SEL:  st_d.dir = wr_data_i;
                WK_ADDR_PEND: clr_mask = ~wr_data_i;
                WK_ADDR_CTRL: st_d.gie = wr_data_i[W-1];
                default:      st_d     = st_q;
            endcase
        end
        // set has priority over clear in the same cycle
        st_d.pend = (st_q.pend & ~clr_mask) | (hit_i & st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign dir_o  = st_q.dir;
    assign pend_o = st_q.pend;
    assign gie_o  = st_q.gie;
endmodule

// File: rtl/edge_wake_ctrl.sv
module edge_wake_ctrl
    import wk_pkg::*;
#(
    parameter int unsigned NPINS       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPINS-1:0]     pins_i,
    input  logic                 wr_en_i,
    input  logic [WK_ADDR_W-1:0] wr_addr_i,
    input  logic [NPINS-1:0]     wr_data_i,
    input  logic [WK_ADDR_W-1:0] rd_addr_i,
    output logic [NPINS-1:0]     rd_data_o,
    output logic                 irq_o,
    output logic                 halt_exit_o
);
    logic [NPINS-1:0] pins_sync;
    logic [NPINS-1:0] hit;
    logic [NPINS-1:0] en_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] pend_q;
    logic             gie_q;
    logic             any_armed;

    wk_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_i),
        .sync_o  (pins_sync)
    );

    wk_edge #(.W(NPINS)) i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (pins_sync),
        .dir_i (dir_q),
        .hit_o (hit)
    );

    wk_regs #(.W(NPINS)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .hit_i     (hit),
        .en_o      (en_q),
        .dir_o     (dir_q),
        .pend_o    (pend_q),
        .gie_o     (gie_q)
    );

    always_comb begin
        any_armed   = |(pend_q & en_q);
        halt_exit_o = any_armed;
        irq_o       = any_armed & gie_q;
        case (wk_addr_e'(rd_addr_i))
            WK_ADDR_EN:   rd_data_o = en_q;
            WK_ADDR_SEL:  rd_data_o = dir_q;
            WK_ADDR_PEND: rd_data_o = pend_q;
            WK_ADDR_CTRL: rd_data_o = {gie_q, {(NPINS-1){1'b0}}};
            default:      rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/wk_checker.sv
module wk_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [1:0]   wr_addr,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] en_q,
    input logic [W-1:0] pend_q,
    input logic         gie_q,
    input logic         irq,
    input logic         halt_exit
);
    assert_irq_needs_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gie_q);

    assert_irq_implies_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> halt_exit);

    assert_no_set_when_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

    assert_no_clear_without_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 2'd2) |=> ((~pend_q & $past(pend_q)) == '0));

    assert_ctrl_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3) |=> (gie_q == $past(wr_data[W-1])));
endmodule

bind edge_wake_ctrl wk_checker #(.W(NPINS)) i_wk_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en_i),
    .wr_addr   (wr_addr_i),
    .wr_data   (wr_data_i),
    .en_q      (en_q),
    .pend_q    (pend_q),
    .gie_q     (gie_q),
    .irq       (irq_o),
    .halt_exit (halt_exit_o)
);

// File: tb/test_edge_wake_ctrl.sv
module test_edge_wake_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pins = 8'h00;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       irq;
    logic       halt_exit;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    edge_wake_ctrl i_edge_wake_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pins_i      (pins),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .irq_o       (irq),
        .halt_exit_o (halt_exit)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reg", {24'd0, v}, 32'd0);
        end
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 halt", {31'd0, halt_exit}, 32'd0);

        // R11: control register keeps only bit 7
        wr(2'd3, 8'hFF);
        rd(2'd3, v);
        chk("R11 ctrl", {24'd0, v}, 32'h80);

        // Sweep every pin, direction and enable value
        for (int p = 0; p < 8; p++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int en = 0; en < 2; en++) begin
                    logic       g;
                    logic [7:0] exp_p;
                    g     = 1'((p + pol + en) % 2);
                    exp_p = en[0] ? (8'h01 << p) : 8'h00;
                    wr(2'd3, {g, 7'd0});
                    wr(2'd0, en[0] ? (8'h01 << p) : 8'h00);
                    wr(2'd1, pol[0] ? (8'h01 << p) : 8'h00);
                    rd(2'd1, v);
                    chk("R11 dir", {24'd0, v}, {24'd0, pol[0] ? (8'h01 << p) : 8'h00});
                    @(negedge clk);
                    pins[p] = pol[0];
                    settle();
                    wr(2'd2, 8'h00);
                    rd(2'd2, v);
                    chk("R6 clear", {24'd0, v}, 32'd0);
                    @(negedge clk);
                    pins[p] = ~pol[0];
                    repeat (2) @(negedge clk);
                    rd(2'd2, v);
                    chk("R2 latency", {24'd0, v}, 32'd0);
                    @(negedge clk);
                    rd(2'd2, v);
                    if (en == 0)
                        chk("R5 disabled", {24'd0, v}, 32'd0);
                    else if (pol == 0)
                        chk("R2 rising", {24'd0, v}, {24'd0, exp_p});
                    else
                        chk("R3 falling", {24'd0, v}, {24'd0, exp_p});
                    chk("R10 halt", {31'd0, halt_exit}, {31'd0, en[0]});
                    chk("R9 irq", {31'd0, irq}, {31'd0, en[0] & g});
                    @(negedge clk);
                    pins[p] = pol[0];
                    settle();
                    rd(2'd2, v);
                    chk("R4 opposite", {24'd0, v}, {24'd0, exp_p});
                end
            end
        end

        // R8: direction change with steady levels
        wr(2'd0, 8'hFF);
        @(negedge clk);
        pins = 8'h0F;
        settle();
        wr(2'd2, 8'h00);
        wr(2'd1, 8'hFF);
        wr(2'd1, 8'h00);
        wr(2'd1, 8'hAA);
        settle();
        rd(2'd2, v);
        chk("R8 dir change", {24'd0, v}, 32'd0);
        chk("R10 idle", {31'd0, halt_exit}, 32'd0);

        // R7: edge and clear at the same clock edge
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h03);
        wr(2'd3, 8'h80);
        @(negedge clk);
        pins = 8'h00;
        settle();
        wr(2'd2, 8'h00);
        @(negedge clk);
        pins = 8'h03;
        settle();
        rd(2'd2, v);
        chk("R2 two pins", {24'd0, v}, 32'h03);
        chk("R9 irq on", {31'd0, irq}, 32'd1);
        @(negedge clk);
        pins = 8'h00;
        settle();
        @(negedge clk);
        pins = 8'h01;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        rd(2'd2, v);
        chk("R7 collision", {24'd0, v}, 32'h01);

        // R6: ones leave bits alone, zeros clear
        wr(2'd2, 8'hFF);
        rd(2'd2, v);
        chk("R6 write ones", {24'd0, v}, 32'h01);
        wr(2'd2, 8'hFE);
        rd(2'd2, v);
        chk("R6 write zero", {24'd0, v}, 32'd0);
        chk("R10 cleared", {31'd0, halt_exit}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule